// File: doc/BRIEF.md
# Interrupt Acknowledge and Cascade Sequencer

This block sits between an interrupt priority resolver and the processor's acknowledge line. It runs the two-pulse acknowledge handshake: on the first low pulse of `ack_n` it captures the level the resolver picked and tells the resolver to take that request into service. On the second low pulse it places an 8-bit vector on its data outputs. The vector is a programmed upper part with the level number in its three low bits.

Several controllers can be chained into a two-tier tree. A master whose winning input carries a slave puts that input number on the cascade lines and stays off the data outputs. Each slave compares the cascade lines with its own ID when the second pulse begins, and only the matching slave answers. The role comes either from a strap pin or, in buffered mode, from a programmed bit. In buffered mode the role pin's function is replaced by a transceiver enable that follows the data drive.

The acknowledge input is assumed to be already synchronous to `clk`. Each edge of `ack_n` takes effect at the next rising clock edge.

Top module: `iack_cascade_seq`

## Requirements
- R1: After reset, every output of the block is zero.
- R2: In the master role, a first `ack_n` falling edge with `req_valid` high gives a one-cycle `take_stb` in the cycle after the edge, with `take_level` equal to `req_level`.
- R3: While the second low pulse lasts, a responding device holds `data_drive` high and `data_out` = {`vec_hi`, level}, with the level in bits 2:0. Both return to zero in the cycle after `ack_n` rises to end the pulse. Outside that window `data_out` is zero.
- R4: If `req_valid` is low at the first falling edge, the sequence is spurious. The level is taken as 7, the vector is {`vec_hi`, 3'b111}, and no `take_stb` or `eoi_stb` is issued.
- R5: In the master role, when `slave_map` bit [level] is set for a valid request, `cas_drive` is high and `cas_out` equals the level. Both hold from the cycle after the first falling edge until the cycle after the second pulse ends, and the master leaves `data_drive` low.
- R6: In the master role, when the winning input has no slave, or the sequence is spurious, `cas_out` and `cas_drive` stay zero and the master drives its own vector.
- R7: In the slave role, the device responds only if `cas_in` equals `own_id` when the second pulse begins. It then drives its vector and, for a non-spurious sequence, gives `take_stb` with the latched level one cycle after the second falling edge. Otherwise `data_drive` stays low and no `take_stb` occurs.
- R8: The role is master when `buffered`=1 and `buf_is_master`=1, or when `buffered`=0 and `role_pin`=1. Otherwise the role is slave. The role is captured at the first falling edge.
- R9: `xcvr_en` equals `data_drive` when `buffered`=1 and is zero when `buffered`=0.
- R10: With `auto_eoi`=1, a non-spurious sequence owned by this device (any master sequence, or a selected slave) gives a one-cycle `eoi_stb` with `eoi_level` = level, in the cycle after the second pulse ends. With `auto_eoi`=0 there is none.
- R11: Changes on `req_valid` and `req_level` after the first falling edge do not alter the vector, the cascade ID or the strobe levels of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_n | input | 1 | Active-low acknowledge pulses, synchronous |
| req_valid | input | 1 | Resolver has an unmasked winning request |
| req_level | input | 3 | Winning level from the resolver |
| vec_hi | input | 5 | Upper five bits of the vector base |
| slave_map | input | 8 | Bit n set: a slave hangs on input n |
| own_id | input | 3 | This device's slave ID |
| auto_eoi | input | 1 | Clear in-service at end of second pulse |
| buffered | input | 1 | Buffered mode select |
| buf_is_master | input | 1 | Programmed role in buffered mode |
| role_pin | input | 1 | Strap role in non-buffered mode (1 = master) |
| cas_in | input | 3 | Cascade lines as seen by a slave |
| cas_out | output | 3 | Cascade ID driven by a master |
| cas_drive | output | 1 | Cascade output enable |
| data_out | output | 8 | Vector byte |
| data_drive | output | 1 | Data output enable |
| xcvr_en | output | 1 | Bus transceiver enable in buffered mode |
| take_stb | output | 1 | Set in-service bit and clear pending bit |
| take_level | output | 3 | Level for `take_stb` |
| eoi_stb | output | 1 | Automatic end-of-interrupt strobe |
| eoi_level | output | 3 | Level for `eoi_stb` |

## Verification
The hardest cases to reach are the ones where the inputs seen at the first pulse differ from those seen at the second. Examples are a slave whose ID match only counts when the second pulse starts, and a resolver that moves to another level in between. The stimulus keeps `cas_in` fixed across a sequence and sets it equal to `own_id` about half the time. It also rewrites `req_valid` and `req_level` right after the first pulse ends, so that a design sampling at the wrong point returns a different vector or strobe level. Directed sequences cover the spurious case, a master with a slave, and both sources of the role.

// File: rtl/iack_pkg.sv
package iack_pkg;
    parameter int LVL_W = 3;
    parameter int VEC_W = 8;
    localparam int NLVL = 1 << LVL_W;
    localparam int HI_W = VEC_W - LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND
    } ack_phase_e;

    // Everything captured at the first acknowledge pulse.
    typedef struct packed {
        lvl_t lvl;
        logic spur;
        logic to_slave;
        logic master;
    } grant_t;

    function automatic vec_t make_vector(input logic [HI_W-1:0] hi, input lvl_t l);
        return {hi, l};
    endfunction
endpackage

// File: rtl/iack_pulse_tracker.sv
module iack_pulse_tracker
    import iack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_n,
    output ack_phase_e phase,
    output logic       first_ev,
    output logic       second_ev,
    output logic       end_ev
);
    logic ack_q;
    logic fall, rise;

    assign fall = ack_q & ~ack_n;
    assign rise = ~ack_q & ack_n;

    assign first_ev  = (phase == PH_IDLE)   && fall;
    assign second_ev = (phase == PH_FIRST)  && fall;
    assign end_ev    = (phase == PH_SECOND) && rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b1;
            phase <= PH_IDLE;
        end else begin
            ack_q <= ack_n;
            unique case (phase)
                PH_IDLE:   if (fall) phase <= PH_FIRST;
                PH_FIRST:  if (fall) phase <= PH_SECOND;
                PH_SECOND: if (rise) phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // R3: the second-pulse phase only lasts while the line is held low
    a_r3_second_while_low: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND) |-> !ack_q);
endmodule

// File: rtl/iack_cascade_router.sv
module iack_cascade_router
    import iack_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            first_ev,
    input  logic            second_ev,
    input  logic            end_ev,
    input  logic            is_master,
    input  logic            req_valid,
    input  lvl_t            req_level,
    input  logic [NLVL-1:0] slave_map,
    input  lvl_t            own_id,
    input  lvl_t            cas_in,
    input  logic            auto_eoi,
    output grant_t          grant,
    output logic            respond_now,
    output lvl_t            cas_out,
    output logic            cas_oe,
    output logic            take_stb,
    output lvl_t            take_level,
    output logic            eoi_stb,
    output lvl_t            eoi_level
);
    logic id_hit;
    logic sel_q;
    logic hits_slave;

    assign id_hit      = (cas_in == own_id);
    assign hits_slave  = is_master & req_valid & slave_map[req_level];
    assign respond_now = grant.master ? ~grant.to_slave : id_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant      <= '0;
            cas_out    <= '0;
            cas_oe     <= 1'b0;
            take_stb   <= 1'b0;
            take_level <= '0;
            eoi_stb    <= 1'b0;
            eoi_level  <= '0;
            sel_q      <= 1'b0;
        end else begin
            take_stb <= 1'b0;
            eoi_stb  <= 1'b0;
            if (first_ev) begin
                grant.lvl      <= req_valid ? req_level : '1;
                grant.spur     <= ~req_valid;
                grant.master   <= is_master;
                grant.to_slave <= hits_slave;
                cas_oe         <= hits_slave;
                cas_out        <= hits_slave ? req_level : '0;
                take_stb       <= is_master & req_valid;
                take_level     <= req_level;
                sel_q          <= 1'b0;
            end
            if (second_ev) begin
                sel_q <= id_hit & ~grant.master;
                if (!grant.master && id_hit && !grant.spur) begin
                    take_stb   <= 1'b1;
                    take_level <= grant.lvl;
                end
            end
            if (end_ev) begin
                cas_oe  <= 1'b0;
                cas_out <= '0;
                if (auto_eoi && !grant.spur && (grant.master || sel_q)) begin
                    eoi_stb   <= 1'b1;
                    eoi_level <= grant.lvl;
                end
            end
        end
    end

    // R5: cascade lines rest at zero when not driven
    a_r5_cas_quiet: assert property (@(posedge clk) disable iff (rst)
        !cas_oe |-> (cas_out == '0));
    // R2: the take strobe lasts a single cycle
    a_r2_take_pulse: assert property (@(posedge clk) disable iff (rst)
        take_stb |=> !take_stb);
    // R4: a spurious sequence never ends in an automatic clear
    a_r4_no_spur_eoi: assert property (@(posedge clk) disable iff (rst)
        eoi_stb |-> !grant.spur);
    // R4: a spurious sequence never takes a request into service
    a_r4_no_spur_take: assert property (@(posedge clk) disable iff (rst)
        take_stb |-> !grant.spur);
endmodule

// File: rtl/iack_vector_driver.sv
module iack_vector_driver
    import iack_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            second_ev,
    input  logic            end_ev,
    input  logic            respond_now,
    input  logic [HI_W-1:0] vec_hi,
    input  lvl_t            lvl,
    input  logic            buffered,
    output vec_t            data_out,
    output logic            data_oe,
    output logic            xcvr_en
);
    vec_t data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            data_oe <= 1'b0;
        end else if (second_ev) begin
            data_oe <= respond_now;
            data_q  <= respond_now ? make_vector(vec_hi, lvl) : '0;
        end else if (end_ev) begin
            data_oe <= 1'b0;
            data_q  <= '0;
        end
    end

    assign data_out = data_q;
    assign xcvr_en  = buffered & data_oe;

    // R3: nothing leaves the data outputs outside the drive window
    a_r3_data_quiet: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0));
endmodule

// File: rtl/iack_cascade_seq.sv
module iack_cascade_seq
    import iack_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ack_n,
    input  logic            req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [HI_W-1:0] vec_hi,
    input  logic [NLVL-1:0] slave_map,
    input  logic [LVL_W-1:0] own_id,
    input  logic            auto_eoi,
    input  logic            buffered,
    input  logic            buf_is_master,
    input  logic            role_pin,
    input  logic [LVL_W-1:0] cas_in,
    output logic [LVL_W-1:0] cas_out,
    output logic            cas_drive,
    output logic [VEC_W-1:0] data_out,
    output logic            data_drive,
    output logic            xcvr_en,
    output logic            take_stb,
    output logic [LVL_W-1:0] take_level,
    output logic            eoi_stb,
    output logic [LVL_W-1:0] eoi_level
);
    ack_phase_e phase;
    logic       first_ev, second_ev, end_ev;
    logic       is_master;
    logic       respond_now;
    grant_t     grant;

    // R8: role source depends on buffered mode
    assign is_master = buffered ? buf_is_master : role_pin;

    iack_pulse_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .ack_n     (ack_n),
        .phase     (phase),
        .first_ev  (first_ev),
        .second_ev (second_ev),
        .end_ev    (end_ev)
    );

    iack_cascade_router u_route (
        .clk         (clk),
        .rst         (rst),
        .first_ev    (first_ev),
        .second_ev   (second_ev),
        .end_ev      (end_ev),
        .is_master   (is_master),
        .req_valid   (req_valid),
        .req_level   (req_level),
        .slave_map   (slave_map),
        .own_id      (own_id),
        .cas_in      (cas_in),
        .auto_eoi    (auto_eoi),
        .grant       (grant),
        .respond_now (respond_now),
        .cas_out     (cas_out),
        .cas_oe      (cas_drive),
        .take_stb    (take_stb),
        .take_level  (take_level),
        .eoi_stb     (eoi_stb),
        .eoi_level   (eoi_level)
    );

    iack_vector_driver u_vec (
        .clk         (clk),
        .rst         (rst),
        .second_ev   (second_ev),
        .end_ev      (end_ev),
        .respond_now (respond_now),
        .vec_hi      (vec_hi),
        .lvl         (grant.lvl),
        .buffered    (buffered),
        .data_out    (data_out),
        .data_oe     (data_drive),
        .xcvr_en     (xcvr_en)
    );

    // R6: a device never drives the data bus and the cascade lines together
    a_r6_data_xor_cas: assert property (@(posedge clk) disable iff (rst)
        !(data_drive && cas_drive));
    // R3: data is only driven during the second pulse
    a_r3_drive_in_second: assert property (@(posedge clk) disable iff (rst)
        data_drive |-> (phase == PH_SECOND));
    // R7: a slave that drives data was selected by the cascade compare
    a_r7_slave_selected: assert property (@(posedge clk) disable iff (rst)
        (data_drive && !grant.master) |-> $past(cas_in == own_id) || $stable(data_drive));
    // R10: the automatic clear follows the close of the second pulse
    a_r10_eoi_at_end: assert property (@(posedge clk) disable iff (rst)
        eoi_stb |-> (phase == PH_IDLE) && ($past(phase) == PH_SECOND));
endmodule

// File: tb/iack_cascade_seq_bench.sv
module iack_cascade_seq_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       ack_n;
    logic       req_valid;
    logic [2:0] req_level;
    logic [4:0] vec_hi;
    logic [7:0] slave_map;
    logic [2:0] own_id;
    logic       auto_eoi;
    logic       buffered;
    logic       buf_is_master;
    logic       role_pin;
    logic [2:0] cas_in;
    logic [2:0] cas_out;
    logic       cas_drive;
    logic [7:0] data_out;
    logic       data_drive;
    logic       xcvr_en;
    logic       take_stb;
    logic [2:0] take_level;
    logic       eoi_stb;
    logic [2:0] eoi_level;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    iack_cascade_seq u_iack_cascade_seq (
        .clk(clk), .rst(rst), .ack_n(ack_n), .req_valid(req_valid),
        .req_level(req_level), .vec_hi(vec_hi), .slave_map(slave_map),
        .own_id(own_id), .auto_eoi(auto_eoi), .buffered(buffered),
        .buf_is_master(buf_is_master), .role_pin(role_pin), .cas_in(cas_in),
        .cas_out(cas_out), .cas_drive(cas_drive), .data_out(data_out),
        .data_drive(data_drive), .xcvr_en(xcvr_en), .take_stb(take_stb),
        .take_level(take_level), .eoi_stb(eoi_stb), .eoi_level(eoi_level)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic role_master(input logic b, input logic bm, input logic rp);
        return b ? bm : rp;
    endfunction

    function automatic logic [7:0] exp_vector(input logic [4:0] hi, input logic v, input logic [2:0] l);
        return {hi, (v ? l : 3'd7)};
    endfunction

    task automatic run_seq();
        logic m, v, ts, sel, resp, own;
        logic [2:0] lv0, lvl;
        m    = role_master(buffered, buf_is_master, role_pin);
        v    = req_valid;
        lv0  = req_level;
        lvl  = v ? lv0 : 3'd7;
        ts   = m & v & slave_map[lv0];
        sel  = !m && (cas_in == own_id);
        resp = m ? !ts : sel;
        own  = m | sel;
        @(negedge clk) ack_n = 1'b0;
        @(negedge clk);
        chk("R2/R8 take strobe", {7'd0, take_stb}, {7'd0, m & v});
        if (m & v) chk("R2 take level", {5'd0, take_level}, {5'd0, lv0});
        chk("R5/R6 cascade drive", {7'd0, cas_drive}, {7'd0, ts});
        chk("R5/R6 cascade id", {5'd0, cas_out}, {5'd0, (ts ? lv0 : 3'd0)});
        ack_n = 1'b1;
        req_valid = 1'($urandom);   // R11 disturbance
        req_level = 3'($urandom);
        @(negedge clk);
        chk("R2 take single pulse", {7'd0, take_stb}, 8'd0);
        ack_n = 1'b0;
        @(negedge clk);
        chk("R3/R4/R11 vector", data_out, resp ? exp_vector(vec_hi, v, lv0) : 8'd0);
        chk("R3/R7 data drive", {7'd0, data_drive}, {7'd0, resp});
        chk("R9 transceiver enable", {7'd0, xcvr_en}, {7'd0, buffered & resp});
        chk("R7 slave take", {7'd0, take_stb}, {7'd0, sel & v});
        if (sel & v) chk("R7/R11 slave take level", {5'd0, take_level}, {5'd0, lvl});
        chk("R5 cascade hold", {7'd0, cas_drive}, {7'd0, ts});
        @(negedge clk) ack_n = 1'b1;
        @(negedge clk);
        chk("R3 data release", {7'd0, data_drive}, 8'd0);
        chk("R3 data zero", data_out, 8'd0);
        chk("R5 cascade release", {7'd0, cas_drive}, 8'd0);
        chk("R10 eoi strobe", {7'd0, eoi_stb}, {7'd0, auto_eoi & v & own});
        if (auto_eoi & v & own) chk("R10/R11 eoi level", {5'd0, eoi_level}, {5'd0, lvl});
        @(negedge clk);
        chk("R10 eoi single pulse", {7'd0, eoi_stb}, 8'd0);
    endtask

    task automatic set_cfg(input logic b, input logic bm, input logic rp, input logic [7:0] sm,
                           input logic [2:0] id, input logic [2:0] ci, input logic ae,
                           input logic [4:0] hi, input logic v, input logic [2:0] l);
        buffered = b; buf_is_master = bm; role_pin = rp; slave_map = sm;
        own_id = id; cas_in = ci; auto_eoi = ae; vec_hi = hi; req_valid = v; req_level = l;
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0042);
        rst = 1'b1; ack_n = 1'b1;
        set_cfg(0, 0, 1, 8'h00, 3'd0, 3'd0, 1'b0, 5'd1, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset data", data_out, 8'd0);
        chk("R1 reset drives", {4'd0, data_drive, cas_drive, xcvr_en, take_stb}, 8'd0);
        chk("R1 reset cascade", {5'd0, cas_out}, 8'd0);
        chk("R1 reset eoi", {7'd0, eoi_stb}, 8'd0);

        // master, no slave, base 08h, level 3 -> 0Bh (R2, R3, R6, R10)
        set_cfg(0, 0, 1, 8'h00, 3'd0, 3'd0, 1'b1, 5'd1, 1'b1, 3'd3); run_seq();
        // master with slave on input 2 (R5)
        set_cfg(0, 0, 1, 8'h04, 3'd0, 3'd0, 1'b1, 5'd1, 1'b1, 3'd2); run_seq();
        // spurious master -> 0Fh (R4)
        set_cfg(0, 0, 1, 8'hFF, 3'd0, 3'd0, 1'b1, 5'd1, 1'b0, 3'd2); run_seq();
        // slave, matching ID, buffered (R7, R8, R9)
        set_cfg(1, 0, 1, 8'h00, 3'd5, 3'd5, 1'b1, 5'h0E, 1'b1, 3'd4); run_seq();
        // slave, ID mismatch (R7)
        set_cfg(0, 1, 0, 8'h00, 3'd5, 3'd3, 1'b1, 5'h0E, 1'b1, 3'd4); run_seq();
        // buffered master, no automatic clear (R8, R9, R10)
        set_cfg(1, 1, 0, 8'h00, 3'd0, 3'd0, 1'b0, 5'h1F, 1'b1, 3'd7); run_seq();
        // spurious slave selected (R4, R7)
        set_cfg(0, 0, 0, 8'h00, 3'd6, 3'd6, 1'b1, 5'h12, 1'b0, 3'd1); run_seq();

        for (int i = 0; i < 80; i++) begin
            logic [2:0] id;
            id = 3'($urandom);
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), id,
                    ($urandom_range(1, 0) == 1) ? id : 3'($urandom), 1'($urandom),
                    5'($urandom), ($urandom_range(4, 0) != 0), 3'($urandom));
            run_seq();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule